// File: doc/BRIEF.md
# Threshold-Pruned Viterbi Path-Metric Engine

This block is the per-stage metric engine of a Viterbi decoder for a rate-1/4 convolutional code with six delay elements, so the trellis has 64 states. For every group of four received hard bits it updates the path metrics of the trellis. It works through 32 radix-2 butterflies, one per clock, and computes nothing for any butterfly whose two predecessor states are both out of play. After the sweep it subtracts the smallest surviving metric from every stored metric. It then drops every state whose normalised metric is more than a run-time threshold above zero. The survivors of one stage are the only states extended in the next.

All metrics sit in one 64-entry store that is updated in place. A butterfly writes its two results back into the two slots it has just read. To make this work, the slot that holds a given state is found by rotating the state number right by the stage count modulo six. A traceback unit downstream receives three things for each stage: a decision vector, a mask of the states that are still active, and the index of the best state. When the threshold is 255 no state is ever dropped, and the engine behaves as a full 64-state decoder.

Top module: `vit_prune_acs`

## Requirements
- R1: After synchronous reset, `in_ready` is 1 and `out_valid` is 0. State 0 holds metric 0 and is the only active state, so the first stage extends only state 0.
- R2: The successor of state s on input bit u is {s[4:0],u}. The expected code word for that transition has bit k equal to the parity of ({s,u} AND GEN[k]), with u in bit 0 and s[5] in bit 6. The default GEN[0..3] is octal 117, 127, 155, 171. Received bit k of `rx_sym` is compared against code bit k, and the branch metric is the Hamming distance between the two 4-bit words.
- R3: A successor n has two predecessors: {0,n[5:1]} and {1,n[5:1]}. When both are active, n takes the smaller candidate (predecessor metric plus branch metric, saturating at 255). A tie goes to the predecessor whose bit 5 is 0. Decision bit n of `dec_o` is bit 5 of the chosen predecessor.
- R4: A successor with exactly one active predecessor takes that predecessor's candidate, and its decision bit is that predecessor's bit 5. A successor with no active predecessor is inactive, and its decision bit is 0.
- R5: After the sweep, the smallest metric among active successors is subtracted from every active metric. `best_o` is the lowest-numbered state that holds this smallest metric.
- R6: After normalisation, a state stays active only if its metric is no greater than the threshold. `act_o[s]` is 1 exactly for such states, and only active states are extended in the next stage. With a threshold of 255, every state that can be reached stays active.
- R7: A symbol is accepted on a rising edge where `in_valid` and `in_ready` are both 1. From there `in_ready` is 0 until results appear. `out_valid` is a one-cycle pulse on the 33rd rising edge after the accepting edge, and on that same edge `in_ready` returns to 1.
- R8: While `out_valid` is high, `best_o` names a state whose bit in `act_o` is set.
- R9: The threshold is captured on the accepting edge. Changes on `thr` during the sweep have no effect on that stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A received symbol group is offered |
| in_ready | output | 1 | Engine idle, able to accept a group |
| rx_sym | input | 4 | Received hard bits, bit k against generator k |
| thr | input | 8 | Pruning threshold, captured at acceptance |
| out_valid | output | 1 | One-cycle pulse: stage results valid |
| dec_o | output | 64 | Per-state survivor decision bits |
| act_o | output | 64 | Per-state active mask after pruning |
| best_o | output | 6 | Index of the best state |

## Verification
An error in the stored metrics, in the slot rotation, or in the active flags does not show up in the stage where it occurs. It appears one stage later, at the ports: successors are wrong in `dec_o`, states are missing or extra in `act_o`, or `best_o` moves. Each of these surfaces within 33 cycles of the next acceptance. A bad rotation only shows at the stages where the rotation wraps, so long runs that span several six-stage cycles are needed. A pruning error shows up at once in the mask. Thresholds of 0, small values and 255 are all used, so that the dropped-state paths and the full-trellis path are both exercised.

// File: rtl/vit_pkg.sv
package vit_pkg;
    localparam int ST_BITS = 6;
    localparam int NST     = 1 << ST_BITS;
    localparam int NBF     = NST / 2;
    localparam int MW      = 8;
    localparam int NOUT    = 4;
    localparam int BMW     = 3;
    localparam int ROTW    = 3;

    typedef logic [MW-1:0]  metric_t;
    typedef logic [BMW-1:0] bm_t;

    typedef struct packed {
        logic    act;
        metric_t m;
    } slot_t;

    typedef enum logic [1:0] {PH_IDLE, PH_SWEEP, PH_FIN} phase_e;

    // rotate a state number right by n places (n < ST_BITS)
    function automatic logic [ST_BITS-1:0] rot_right(input logic [ST_BITS-1:0] s,
                                                     input logic [ROTW-1:0] n);
        logic [ST_BITS-1:0] r;
        r = s;
        for (int k = 0; k < ST_BITS; k++)
            if (k < int'(n)) r = {r[0], r[ST_BITS-1:1]};
        return r;
    endfunction

    function automatic metric_t sat_add(input metric_t a, input bm_t b);
        logic [MW:0] s;
        s = {1'b0, a} + {{(MW+1-BMW){1'b0}}, b};
        return s[MW] ? {MW{1'b1}} : s[MW-1:0];
    endfunction
endpackage

// File: rtl/vit_bmu.sv
module vit_bmu
    import vit_pkg::*;
#(
    parameter logic [NOUT-1:0][ST_BITS:0] GEN = {7'o171, 7'o155, 7'o127, 7'o117}
) (
    input  logic [ST_BITS-2:0] bfly,
    input  logic [NOUT-1:0]    rx,
    output bm_t                bm [2][2]   // [predecessor msb][input bit]
);
    for (genvar p = 0; p < 2; p++) begin : g_pred
        for (genvar u = 0; u < 2; u++) begin : g_in
            logic [ST_BITS:0]  word;
            logic [NOUT-1:0]   diff;
            assign word = {1'(p), bfly, 1'(u)};
            always_comb begin
                for (int k = 0; k < NOUT; k++)
                    diff[k] = (^(word & GEN[k])) ^ rx[k];
                bm[p][u] = bm_t'($countones(diff));
            end
        end
    end
endmodule

// File: rtl/vit_acs.sv
module vit_acs
    import vit_pkg::*;
(
    input  slot_t lo,          // predecessor with msb 0
    input  slot_t hi,          // predecessor with msb 1
    input  bm_t   bm [2][2],
    output slot_t nxt [2],     // successor index lsb = input bit
    output logic  dec [2],
    output logic  any_act
);
    assign any_act = lo.act | hi.act;

    for (genvar u = 0; u < 2; u++) begin : g_succ
        metric_t c_lo, c_hi;
        logic    take_hi;
        assign c_lo    = sat_add(lo.m, bm[0][u]);
        assign c_hi    = sat_add(hi.m, bm[1][u]);
        assign take_hi = hi.act & (~lo.act | (c_hi < c_lo));
        assign nxt[u]  = '{act: any_act, m: take_hi ? c_hi : c_lo};
        assign dec[u]  = take_hi;
    end
endmodule

// File: rtl/vit_prune_acs.sv
module vit_prune_acs
    import vit_pkg::*;
#(
    parameter logic [NOUT-1:0][ST_BITS:0] GEN = {7'o171, 7'o155, 7'o127, 7'o117}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [NOUT-1:0]   rx_sym,
    input  logic [MW-1:0]     thr,
    output logic              out_valid,
    output logic [NST-1:0]    dec_o,
    output logic [NST-1:0]    act_o,
    output logic [ST_BITS-1:0] best_o
);
    localparam int BW = ST_BITS - 1;

    phase_e              phase;
    slot_t               mem [NST];
    logic [BW-1:0]       bfly;
    logic [ROTW-1:0]     rot, rot_nx;
    logic [NOUT-1:0]     rx_q;
    metric_t             thr_q, min_q, min_c;
    logic [ST_BITS-1:0]  best_q, best_c;
    logic                found_q, found_c;
    logic [NST-1:0]      dec_q, keep;
    logic [ST_BITS-1:0]  a_lo, a_hi;
    bm_t                 bm [2][2];
    slot_t               nxt [2];
    logic                dec [2];
    logic                any_act;

    assign in_ready = (phase == PH_IDLE);
    assign rot_nx   = (rot == ROTW'(ST_BITS-1)) ? '0 : rot + 1'b1;
    assign a_lo     = rot_right({1'b0, bfly}, rot);
    assign a_hi     = rot_right({1'b1, bfly}, rot);

    vit_bmu #(.GEN(GEN)) i_bmu (.bfly(bfly), .rx(rx_q), .bm(bm));

    vit_acs i_acs (
        .lo(mem[a_lo]), .hi(mem[a_hi]), .bm(bm),
        .nxt(nxt), .dec(dec), .any_act(any_act)
    );

    // running minimum; lower state index wins ties
    always_comb begin
        min_c   = min_q;
        best_c  = best_q;
        found_c = found_q;
        for (int u = 0; u < 2; u++) begin
            if (nxt[u].act && (!found_c || nxt[u].m < min_c)) begin
                min_c   = nxt[u].m;
                best_c  = {bfly, 1'(u)};
                found_c = 1'b1;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NST; i++)
            keep[i] = mem[i].act && ((mem[i].m - min_q) <= thr_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            bfly      <= '0;
            rot       <= '0;
            rx_q      <= '0;
            thr_q     <= '0;
            min_q     <= '0;
            best_q    <= '0;
            found_q   <= 1'b0;
            dec_q     <= '0;
            out_valid <= 1'b0;
            dec_o     <= '0;
            act_o     <= '0;
            best_o    <= '0;
            for (int i = 0; i < NST; i++) mem[i] <= '{act: 1'b0, m: '0};
            mem[0]    <= '{act: 1'b1, m: '0};
        end else begin
            out_valid <= 1'b0;
            case (phase)
                PH_IDLE: if (in_valid) begin
                    rx_q    <= rx_sym;
                    thr_q   <= thr;
                    bfly    <= '0;
                    dec_q   <= '0;
                    min_q   <= '1;
                    best_q  <= '0;
                    found_q <= 1'b0;
                    phase   <= PH_SWEEP;
                end
                PH_SWEEP: begin
                    if (any_act) begin
                        mem[a_lo] <= nxt[0];
                        mem[a_hi] <= nxt[1];
                        dec_q[{bfly, 1'b0}] <= dec[0];
                        dec_q[{bfly, 1'b1}] <= dec[1];
                        min_q   <= min_c;
                        best_q  <= best_c;
                        found_q <= found_c;
                    end
                    bfly <= bfly + 1'b1;
                    if (bfly == BW'(NBF-1)) phase <= PH_FIN;
                end
                PH_FIN: begin
                    for (int i = 0; i < NST; i++)
                        mem[i] <= '{act: keep[i], m: mem[i].m - min_q};
                    for (int s = 0; s < NST; s++)
                        act_o[s] <= keep[rot_right(ST_BITS'(s), rot_nx)];
                    dec_o     <= dec_q;
                    best_o    <= best_q;
                    rot       <= rot_nx;
                    out_valid <= 1'b1;
                    phase     <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/vit_prune_acs_chk.sv
module vit_prune_acs_chk
    import vit_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_ready,
    input logic               out_valid,
    input logic [NST-1:0]     act_o,
    input logic [ST_BITS-1:0] best_o
);
    // R7
    pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R7
    ready_with_result_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> in_ready);

    // R7
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    // R8
    best_active_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> act_o[best_o]);

    // R6
    mask_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (act_o != '0));
endmodule

bind vit_prune_acs vit_prune_acs_chk i_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .act_o(act_o), .best_o(best_o)
);

// File: tb/test_vit_prune_acs.sv
module test_vit_prune_acs;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [3:0][6:0] GEN = {7'o171, 7'o155, 7'o127, 7'o117};

    logic        clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
    logic        in_ready, out_valid;
    logic [3:0]  rx_sym = '0;
    logic [7:0]  thr = 8'd255;
    logic [63:0] dec_o, act_o;
    logic [5:0]  best_o;

    vit_prune_acs i_vit_prune_acs (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .rx_sym(rx_sym), .thr(thr), .out_valid(out_valid),
        .dec_o(dec_o), .act_o(act_o), .best_o(best_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [63:0] dec;
        logic [63:0] act;
        logic [5:0]  best;
        int          acc;
        bit          late_thr;
    } exp_t;

    exp_t expq[$];
    int   checks = 0, fails = 0, cyc = 0;
    int   rm [64];
    bit   rv [64];
    logic [5:0] enc_st = '0;

    always @(posedge clk) cyc <= cyc + 1;

    // R2: expected code word for predecessor p and input u
    function automatic logic [3:0] code_of(logic [5:0] p, logic u);
        logic [6:0] w = {p, u};
        logic [3:0] c;
        for (int k = 0; k < 4; k++) c[k] = ^(w & GEN[k]);
        return c;
    endfunction

    function automatic int hd(logic [3:0] a, logic [3:0] b);
        return $countones(a ^ b);
    endfunction

    task automatic ref_step(input logic [3:0] rx, input int t, output exp_t e);
        int nm [64];
        bit nv [64];
        int mn = 256;
        e.dec = '0;
        e.best = '0;
        for (int n = 0; n < 64; n++) begin
            logic [5:0] p0 = {1'b0, 6'(n) >> 1};
            logic [5:0] p1 = {1'b1, 5'(n >> 1)};
            logic u = 1'(n);
            int c0 = rm[p0] + hd(rx, code_of(p0, u));
            int c1 = rm[p1] + hd(rx, code_of(p1, u));
            bit hi;
            if (c0 > 255) c0 = 255;
            if (c1 > 255) c1 = 255;
            hi = rv[p1] && (!rv[p0] || c1 < c0);     // R3 R4
            nv[n] = rv[p0] || rv[p1];
            nm[n] = hi ? c1 : c0;
            e.dec[n] = nv[n] && hi;
        end
        for (int n = 0; n < 64; n++)                 // R5
            if (nv[n] && nm[n] < mn) begin mn = nm[n]; e.best = 6'(n); end
        e.act = '0;
        for (int n = 0; n < 64; n++) begin           // R6
            rm[n] = nv[n] ? nm[n] - mn : 0;
            rv[n] = nv[n] && (rm[n] <= t);
            e.act[n] = rv[n];
        end
    endtask

    task automatic send(input logic [3:0] rx, input int t, input bit late);
        exp_t e;
        ref_step(rx, t, e);
        e.late_thr = late;
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; rx_sym = rx; thr = 8'(t);
        e.acc = cyc + 1;
        expq.push_back(e);
        @(negedge clk);
        in_valid = 1'b0;
        if (late) thr = 8'd0;   // R9: must not affect the running stage
    endtask

    task automatic encode_send(input int t, input int err_mod, input bit late);
        logic u = 1'($urandom);
        logic [3:0] c = code_of(enc_st, u);
        if (err_mod > 0 && ($urandom % err_mod) == 0) c[$urandom % 4] ^= 1'b1;
        enc_st = {enc_st[4:0], u};
        send(c, t, late);
    endtask

    // monitor: pops expected items as stage results appear
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && out_valid) begin
                exp_t e;
                if (expq.size() == 0) begin
                    fails++; checks++;
                    $display("FAIL R7 unexpected out_valid: actual 1 expected 0");
                end else begin
                    e = expq.pop_front();
                    checks++;
                    if (cyc - e.acc != 33) begin
                        fails++;
                        $display("FAIL R7 latency: actual %0d expected 33", cyc - e.acc);
                    end
                    checks++;
                    if (dec_o !== e.dec) begin
                        fails++;
                        $display("FAIL R3 R4 dec_o: actual %h expected %h", dec_o, e.dec);
                    end
                    checks++;
                    if (act_o !== e.act) begin
                        fails++;
                        $display("FAIL %s act_o: actual %h expected %h",
                                 e.late_thr ? "R9" : "R6", act_o, e.act);
                    end
                    checks++;
                    if (best_o !== e.best) begin
                        fails++;
                        $display("FAIL R5 R8 best_o: actual %0d expected %0d", best_o, e.best);
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int n = 0; n < 64; n++) begin rm[n] = 0; rv[n] = (n == 0); end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;                                    // R1
        if (in_ready !== 1'b1 || out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: actual ready=%b valid=%b expected ready=1 valid=0",
                     in_ready, out_valid);
        end
        // R1: first stage extends only state 0 (noise-free zero input)
        send(4'b0000, 255, 1'b0);
        for (int i = 0; i < 40; i++) encode_send(255, 0, 1'b0);   // R2 full trellis
        for (int i = 0; i < 40; i++) encode_send(255, 3, 1'b0);   // R3 noisy, full
        for (int i = 0; i < 40; i++) encode_send(4, 3, 1'b0);     // R6 pruning
        for (int i = 0; i < 30; i++) encode_send(0, 2, 1'b0);     // R4 tight pruning
        for (int i = 0; i < 12; i++) encode_send(2, 3, 1'b1);     // R9 late threshold
        for (int i = 0; i < 20; i++) send(4'($urandom), 6, 1'b0); // R5 random symbols
        while (expq.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule